// File: doc/BRIEF.md
# Event Status and Dual Interrupt Unit

This block keeps a status word for a card host controller and turns it into two interrupt lines. Other parts of the controller raise event bits by pulsing a set input. Each event bit stays set until software writes a one to the matching position of the clear register. The upper bits of the status word are not stored here. They are live level inputs that report FIFO fill and activity, so software cannot clear them.

Two independent mask registers choose which status bits drive each interrupt line. Each line is registered and goes high when its mask selects any status bit that is set. Software reaches all registers through a 32-bit register port with a 12-bit byte address. The top 32 bytes of the 4 KB window return a fixed eight-byte identification sequence, one byte per word.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status word, both mask registers and both interrupt outputs read zero.
- R2: A one on bit i (0 <= i <= 10) of the event set input sets status bit i at the next clock edge, and the bit stays set with no further pulse.
- R3: Writing value V to the clear register at offset 0x38 clears exactly the status bits where V has a one and the bit index is 10 or below. Bits 31:11 of V have no effect.
- R4: Status bits 21:11 always show the level inputs as sampled at the previous clock edge. A clear write does not change them.
- R5: When a set pulse and a clear write target the same bit in the same cycle, the bit ends up set.
- R6: Interrupt output k is high in the cycle after (status & mask_k) != 0 holds, and low in the cycle after it is zero. Mask 0 is at offset 0x3C and mask 1 at 0x40.
- R7: A read at offset 0x34 returns the status word in bits 21:0, with zeros above. Reads of 0x3C and 0x40 return the mask values. Read data is valid one cycle after the read strobe.
- R8: A read at offset 0xFE0 + 4*j (j = 0..7) returns byte j of the sequence 81, 11, 04, 00, 0D, F0, 05, B1 (hex) in bits 7:0, with zeros above. Any other unmapped offset reads zero.
- R9: Bit 9 of the status word is unused and always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address within the 4 KB window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| evt_set | input | 11 | One-cycle pulses that set event bits 10:0 |
| lvl_in | input | 11 | Live levels for status bits 21:11 |
| irq_out | output | 2 | Interrupt lines, one for each mask |

## Verification
The clear path is exercised with every single-bit clear value across bits 0..31. This shows whether each clear reaches exactly its own bit and whether clears above bit 10 leak into the live bits. Walking single-bit masks over every status position, on both lines, shows whether each line uses its own mask and whether the mask and status bits are aligned. Same-cycle set and clear collisions show which side wins. All eight identification words and one unmapped offset are read, which catches a wrong table index or a missing default.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int EVT_BITS = 11;
  localparam int LVL_BITS = 11;
  localparam int STAT_BITS = EVT_BITS + LVL_BITS;
  localparam int NUM_IRQ = 2;
  localparam logic [11:0] OFF_STATUS = 12'h034;
  localparam logic [11:0] OFF_CLEAR  = 12'h038;
  localparam logic [11:0] OFF_MASK0  = 12'h03C;
  localparam logic [11:0] OFF_MASK1  = 12'h040;
  localparam logic [11:0] OFF_IDBASE = 12'hFE0;
  localparam logic [EVT_BITS-1:0] EVT_IMPL = 11'b101_1111_1111;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h81;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/evt_bank.sv
module evt_bank #(
  parameter int W = 11,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (rst) q_o[i] <= 1'b0;
        else if (set_i[i]) q_o[i] <= 1'b1;
        else if (clr_i[i]) q_o[i] <= 1'b0;
      end
      // R5
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i[i] |=> q_o[i]);
    end else begin : g_tie
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else irq_o <= |(stat_i & mask_i);
  end
  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_i & mask_i) == '0 |=> !irq_o);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [11:0]         reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [EVT_BITS-1:0] evt_set,
  input  logic [LVL_BITS-1:0] lvl_in,
  output logic [NUM_IRQ-1:0]  irq_out
);
  logic [EVT_BITS-1:0]  evt_q, clr_vec;
  logic [LVL_BITS-1:0]  lvl_q;
  logic [STAT_BITS-1:0] status;
  logic [31:0]          mask_q [NUM_IRQ];

  assign clr_vec = (reg_wr && reg_addr == OFF_CLEAR) ? reg_wdata[EVT_BITS-1:0] : '0;

  evt_bank #(.W(EVT_BITS), .IMPL(EVT_IMPL)) u_evt (
    .clk(clk), .rst(rst), .set_i(evt_set), .clr_i(clr_vec), .q_o(evt_q));

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else lvl_q <= lvl_in;
  end

  assign status = {lvl_q, evt_q};

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    localparam logic [11:0] MOFF = OFF_MASK0 + 12'(4 * k);
    always_ff @(posedge clk) begin
      if (rst) mask_q[k] <= '0;
      else if (reg_wr && reg_addr == MOFF) mask_q[k] <= reg_wdata;
    end
    irq_combine #(.W(STAT_BITS)) u_comb (
      .clk(clk), .rst(rst), .stat_i(status),
      .mask_i(mask_q[k][STAT_BITS-1:0]), .irq_o(irq_out[k]));
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      if (reg_addr >= OFF_IDBASE && reg_addr[1:0] == 2'b00)
        reg_rdata <= {24'h0, id_byte(reg_addr[4:2])};
      else case (reg_addr)
        OFF_STATUS: reg_rdata <= 32'(status);
        OFF_MASK0:  reg_rdata <= mask_q[0];
        OFF_MASK1:  reg_rdata <= mask_q[1];
        default:    reg_rdata <= '0;
      endcase
    end
  end

  // R4
  lvl_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> status[STAT_BITS-1:EVT_BITS] == $past(lvl_in));
  // R3
  clr_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_vec[0] && !evt_set[0]) |=> !status[0]);
  // R9
  unused_bit_chk: assert property (@(posedge clk) disable iff (rst) !status[9]);
  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (status[3] && !clr_vec[3]) |=> status[3]);
endmodule

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [10:0] evt_set = 0, lvl_in = 0;
  logic [1:0] irq_out;
  int checks = 0, fails = 0;
  logic [7:0] idtab [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  irq_status_unit dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1; reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(posedge clk); #1; reg_rd = 0; d = reg_rdata;
  endtask

  task automatic pulse(input logic [10:0] v);
    evt_set = v; @(posedge clk); #1; evt_set = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [21:0] st;
    repeat (3) @(posedge clk); #1; rst = 0;
    rd(12'h034, d); chk("R1 status", d, 0);
    rd(12'h03C, d); chk("R1 mask0", d, 0);
    rd(12'h040, d); chk("R1 mask1", d, 0);
    chk("R1 irq", {30'h0, irq_out}, 0);

    // R2 and R3: single-bit clear sweep over all 32 positions
    for (int b = 0; b < 32; b++) begin
      lvl_in = 11'h5A5; pulse(11'h7FF);
      wr(12'h038, 32'h1 << b);
      rd(12'h034, d);
      st = {11'h5A5, 11'h5FF};
      if (b <= 10) st[b] = 1'b0;
      chk($sformatf("R3 clear bit %0d", b), d, {10'h0, st});
    end
    // R2 sticky
    wr(12'h038, 32'h7FF); pulse(11'h010);
    repeat (5) @(posedge clk); #1;
    rd(12'h034, d); chk("R2 sticky", d[10:0], 32'h010);
    // R9
    pulse(11'h200); rd(12'h034, d); chk("R9 bit9", {31'h0, d[9]}, 0);
    // R4 level tracking and clear immunity
    lvl_in = 11'h3C3; @(posedge clk); #1;
    wr(12'h038, 32'hFFFF_FFFF);
    rd(12'h034, d); chk("R4 live", d[21:11], 32'h3C3);
    chk("R4 events cleared", d[10:0], 0);
    // R5 collision
    evt_set = 11'h041; reg_wr = 1; reg_addr = 12'h038; reg_wdata = 32'h41;
    @(posedge clk); #1; evt_set = 0; reg_wr = 0;
    rd(12'h034, d); chk("R5 set wins", d[10:0], 32'h041);
    wr(12'h038, 32'h7FF);
    // R6 walking masks on both lines
    lvl_in = 0; @(posedge clk); #1;
    for (int k = 0; k < 2; k++) begin
      for (int b = 0; b < 22; b++) begin
        wr(12'h038, 32'h7FF);
        wr(k ? 12'h040 : 12'h03C, 32'h1 << b);
        if (b < 11) pulse(11'h1 << b); else begin lvl_in = 11'h1 << (b - 11); @(posedge clk); #1; end
        @(posedge clk); #1;
        chk($sformatf("R6 line %0d bit %0d", k, b), {30'h0, irq_out},
            (b == 9) ? 32'h0 : (32'h1 << k));
        lvl_in = 0; wr(12'h038, 32'h7FF);
        @(posedge clk); @(posedge clk); #1;
        chk($sformatf("R6 line %0d bit %0d low", k, b), {30'h0, irq_out}, 0);
      end
      wr(k ? 12'h040 : 12'h03C, 0);
    end
    // R7 mask readback
    wr(12'h03C, 32'hDEADBEEF); wr(12'h040, 32'h12345678);
    rd(12'h03C, d); chk("R7 mask0", d, 32'hDEADBEEF);
    rd(12'h040, d); chk("R7 mask1", d, 32'h12345678);
    // R8 id table and unmapped
    for (int j = 0; j < 8; j++) begin
      rd(12'hFE0 + 12'(4 * j), d); chk($sformatf("R8 id %0d", j), d, {24'h0, idtab[j]});
    end
    rd(12'h100, d); chk("R8 unmapped", d, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule